// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Blanking Chain

This block turns binary-coded decimal digits into drive patterns for seven-segment displays. Every segment drive is active LOW. Each digit has its own decoder with three controls: a lamp-test input that lights every segment, a ripple-blanking input, and a forced-blanking input. A digit blanks itself when its value is zero and its ripple-blanking input is active. When it blanks itself this way, it pulls its ripple-blanking output LOW so that the next digit in the chain can also blank a zero.

The top module places a row of these decoders. The row has an integer field of `INT_DIGITS` digits and a fraction field of `FRAC_DIGITS` digits, and the decimal point sits between the two fields. In the integer field the blanking chain runs from the most significant digit towards the point, so leading zeros vanish and any zero after a nonzero digit stays lit. In the fraction field the chain runs from the rightmost digit towards the point, so trailing zeros vanish. On a single physical device, blanking input and ripple-blanking output are one pin. Here they are a separate input and a separate output, and the output follows the level that the shared pin would have.

Top module: `segdec_chain`

## Requirements
- R1: Segment vector layout per digit is bit 0 = a, bit 1 = b, … bit 6 = g, with 0 meaning lit; codes 0 to 9 light the standard glyphs (0 lights a–f, 1 lights b and c, 6 includes a, 9 includes d, 7 lights a, b, c).
- R2: Codes 10 to 15 light only segment g (vector 7'b0111111), and such a digit is never zero-blanked.
- R3: A digit with value 0, ripple-blanking input LOW, lamp test inactive and forced blanking inactive drives all segments off (7'b1111111) and drives its ripple-blanking output LOW.
- R4: A digit with a nonzero value, or with its ripple-blanking input HIGH, is displayed, and its ripple-blanking output is HIGH while forced blanking is inactive.
- R5: In the integer field the most significant digit takes `rbiIntN`, and every other integer digit takes the ripple-blanking output of the digit to its left, so only leading zeros are suppressed.
- R6: In the fraction field the rightmost digit takes `rbiFracN`, and every other fraction digit takes the ripple-blanking output of the digit to its right, so only trailing zeros are suppressed.
- R7: With `lampTestN` LOW, a digit whose forced blanking is inactive lights all seven segments (vector 0) whatever its value, is never zero-blanked, and holds its ripple-blanking output HIGH.
- R8: A LOW forced-blanking input turns every segment of that digit off and drives its ripple-blanking output LOW, whatever the value, the ripple input and the lamp test are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lampTestN | input | 1 | Lamp test, active LOW, shared by all digits |
| rbiIntN | input | 1 | Ripple-blanking input of the most significant integer digit, active LOW |
| rbiFracN | input | 1 | Ripple-blanking input of the rightmost fraction digit, active LOW |
| digitsIn | input | 4*(INT_DIGITS+FRAC_DIGITS) | BCD digits; digit k at bits 4k+3:4k, digit 0 is the rightmost |
| blankInN | input | INT_DIGITS+FRAC_DIGITS | Forced blanking per digit, active LOW |
| segN | output | 7*(INT_DIGITS+FRAC_DIGITS) | Segment drives; digit k at bits 7k+6:7k, active LOW |
| rboN | output | INT_DIGITS+FRAC_DIGITS | Ripple-blanking output per digit, active LOW |

## Verification
The bench builds the row with two integer digits and two fraction digits, which is the smallest layout where each chain has both an end digit and a digit fed by a neighbour. With four digits the full space of 65536 value combinations can be swept with both ripple inputs active. That sweep covers every place a leading or trailing zero can sit, every code from 10 to 15 in every position, and every zero that follows a nonzero digit. Further sweeps vary the ripple inputs, the lamp test and all sixteen forced-blanking patterns, so that each override can be checked against each other control.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [SEG_W-1:0] segVec_t;
  typedef logic [BCD_W-1:0] bcdVal_t;

  // strobes from the control half to the glyph datapath
  typedef struct packed {
    logic darkAll;  // force every segment off
    logic lampAll;  // force every segment on
  } segStrobes_t;
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  bcdVal_t     bcdVal,
  input  logic        lampTestN,
  input  logic        rbiN,
  input  logic        blankInN,
  output segStrobes_t strobes,
  output logic        rboN
);
  logic isZero;
  logic zeroHit;

  always_comb begin
    isZero  = (bcdVal == '0);
    // lamp test suspends zero suppression
    zeroHit = isZero & ~rbiN & lampTestN;
    strobes.darkAll = ~blankInN | zeroHit;
    strobes.lampAll = ~lampTestN;
    // level of the shared pin: low if driven by suppression or from outside
    rboN = blankInN & ~zeroHit;
  end
endmodule

// File: rtl/segdec_path.sv
module segdec_path
  import segdec_pkg::*;
(
  input  bcdVal_t     bcdVal,
  input  segStrobes_t strobes,
  output segVec_t     segN
);
  segVec_t glyph;  // active high, bit0 = a

  always_comb begin
    unique case (bcdVal)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = 7'h40;  // codes 10..15: middle bar only
    endcase

    if (strobes.darkAll)      segN = '1;
    else if (strobes.lampAll) segN = '0;
    else                      segN = ~glyph;
  end
endmodule

// File: rtl/segdec_digit.sv
module segdec_digit
  import segdec_pkg::*;
(
  input  bcdVal_t bcdVal,
  input  logic    lampTestN,
  input  logic    rbiN,
  input  logic    blankInN,
  output segVec_t segN,
  output logic    rboN
);
  segStrobes_t strobes;

  segdec_ctrl ctrl_i (
    .bcdVal    (bcdVal),
    .lampTestN (lampTestN),
    .rbiN      (rbiN),
    .blankInN  (blankInN),
    .strobes   (strobes),
    .rboN      (rboN)
  );

  segdec_path path_i (
    .bcdVal  (bcdVal),
    .strobes (strobes),
    .segN    (segN)
  );

  always_comb begin
    if (!$isunknown({bcdVal, lampTestN, rbiN, blankInN, segN, rboN})) begin
      p_ext_blank_r8: assert (blankInN || (segN == '1 && !rboN))
        else $error("forced blank not honoured");
      p_lamp_on_r7: assert (!blankInN || lampTestN || (segN == '0 && rboN))
        else $error("lamp test not honoured");
      p_rbo_dark_r3: assert (rboN || segN == '1)
        else $error("ripple output low on a lit digit");
      p_nonzero_rbo_r4: assert (!blankInN || (bcdVal == '0 && !rbiN) || rboN)
        else $error("ripple output low on a significant digit");
    end
  end
endmodule

// File: rtl/segdec_chain.sv
module segdec_chain
  import segdec_pkg::*;
#(
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 2,
  localparam int NUM_DIGITS = INT_DIGITS + FRAC_DIGITS
) (
  input  logic                        lampTestN,
  input  logic                        rbiIntN,
  input  logic                        rbiFracN,
  input  logic [BCD_W*NUM_DIGITS-1:0] digitsIn,
  input  logic [NUM_DIGITS-1:0]       blankInN,
  output logic [SEG_W*NUM_DIGITS-1:0] segN,
  output logic [NUM_DIGITS-1:0]       rboN
);
  logic [NUM_DIGITS-1:0] rbiN;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : gDigit
    if (k >= FRAC_DIGITS) begin : gInt
      // integer field: chain flows rightwards from the most significant digit
      if (k == NUM_DIGITS - 1) begin : gHead
        assign rbiN[k] = rbiIntN;
      end else begin : gLink
        assign rbiN[k] = rboN[k+1];
      end
    end else begin : gFrac
      // fraction field: chain flows leftwards from the rightmost digit
      if (k == 0) begin : gHead
        assign rbiN[k] = rbiFracN;
      end else begin : gLink
        assign rbiN[k] = rboN[k-1];
      end
    end

    segdec_digit digit_i (
      .bcdVal    (digitsIn[BCD_W*k +: BCD_W]),
      .lampTestN (lampTestN),
      .rbiN      (rbiN[k]),
      .blankInN  (blankInN[k]),
      .segN      (segN[SEG_W*k +: SEG_W]),
      .rboN      (rboN[k])
    );
  end
endmodule

// File: tb/segdec_chain_tb_top.sv
module segdec_chain_tb_top;
  localparam int INT_D = 2;
  localparam int FRAC_D = 2;
  localparam int ND = INT_D + FRAC_D;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic            lampTestN, rbiIntN, rbiFracN;
  logic [4*ND-1:0] digitsIn;
  logic [ND-1:0]   blankInN;
  logic [7*ND-1:0] segN;
  logic [ND-1:0]   rboN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  segdec_chain #(.INT_DIGITS(INT_D), .FRAC_DIGITS(FRAC_D)) dut_i (
    .lampTestN (lampTestN),
    .rbiIntN   (rbiIntN),
    .rbiFracN  (rbiFracN),
    .digitsIn  (digitsIn),
    .blankInN  (blankInN),
    .segN      (segN),
    .rboN      (rboN)
  );

  // lit segment set, active high, from per-segment digit membership masks (R1, R2)
  function automatic logic [6:0] litSet(input int v);
    logic [15:0] m [7];
    logic [6:0] r;
    m[0] = 16'h03ED; m[1] = 16'h039F; m[2] = 16'h03FB; m[3] = 16'h036D;
    m[4] = 16'h0145; m[5] = 16'h0371; m[6] = 16'hFF7C;
    for (int s = 0; s < 7; s++) r[s] = m[s][v];
    return r;
  endfunction

  logic [7*ND-1:0] expSeg;
  logic [ND-1:0]   expRbo;

  task automatic model();
    bit rippleOn;
    bit zb;
    int v;
    // integer field, most significant first (R5)
    rippleOn = !rbiIntN;
    for (int k = ND - 1; k >= FRAC_D; k--) begin
      v = int'(digitsIn[4*k +: 4]);
      zb = lampTestN && v == 0 && rippleOn;
      expRbo[k] = blankInN[k] && !zb;
      rippleOn = !expRbo[k];
      if (!blankInN[k] || zb) expSeg[7*k +: 7] = 7'h7F;
      else if (!lampTestN)    expSeg[7*k +: 7] = 7'h00;
      else                    expSeg[7*k +: 7] = ~litSet(v);
    end
    // fraction field, rightmost first (R6)
    rippleOn = !rbiFracN;
    for (int k = 0; k < FRAC_D; k++) begin
      v = int'(digitsIn[4*k +: 4]);
      zb = lampTestN && v == 0 && rippleOn;
      expRbo[k] = blankInN[k] && !zb;
      rippleOn = !expRbo[k];
      if (!blankInN[k] || zb) expSeg[7*k +: 7] = 7'h7F;
      else if (!lampTestN)    expSeg[7*k +: 7] = 7'h00;
      else                    expSeg[7*k +: 7] = ~litSet(v);
    end
  endtask

  task automatic checkNow(input string tag);
    model();
    total++;
    if (segN !== expSeg || rboN !== expRbo) begin
      bad++;
      $display("FAIL %s digits=%h lt=%b ri=%b rf=%b bl=%b seg=%h/%h rbo=%b/%b (actual/expected)",
               tag, digitsIn, lampTestN, rbiIntN, rbiFracN, blankInN,
               segN, expSeg, rboN, expRbo);
    end
  endtask

  task automatic apply(input logic [4*ND-1:0] d, input logic lt, input logic ri,
                       input logic rf, input logic [ND-1:0] bl, input string tag);
    @(posedge clk);
    digitsIn = d; lampTestN = lt; rbiIntN = ri; rbiFracN = rf; blankInN = bl;
    @(negedge clk);
    checkNow(tag);
  endtask

  initial begin
    lampTestN = 1'b1; rbiIntN = 1'b1; rbiFracN = 1'b1;
    digitsIn = '0; blankInN = '1;
    @(negedge clk);
    checkNow("R4 idle all-zero display");

    // single digit value sweep, no suppression: glyphs R1, R2
    for (int v = 0; v < 16; v++)
      apply({4{4'(v)}}, 1'b1, 1'b1, 1'b1, '1, (v < 10) ? "R1 glyph" : "R2 code 10-15");

    // full sweep with both ripple inputs active: R3 R5 R6 R2
    for (int d = 0; d < 65536; d++)
      apply(16'(d), 1'b1, 1'b0, 1'b0, '1, "R3 R5 R6 chain sweep");

    // ripple inputs held off or split: R4
    for (int d = 0; d < 4096; d++)
      apply(16'(d * 16 + (d % 3)), 1'b1, d[0], d[1], '1, "R4 ripple input high");

    // lamp test against blanking patterns: R7 R8
    for (int b = 0; b < 16; b++)
      for (int p = 0; p < 4; p++)
        apply((p == 0) ? 16'h0000 : (p == 1) ? 16'h0900 : (p == 2) ? 16'hF0A1 : 16'h1008,
              1'b0, p[0], p[1], 4'(b), "R7 lamp test");

    // forced blanking without lamp test: R8
    for (int b = 0; b < 16; b++)
      for (int p = 0; p < 4; p++)
        apply((p == 0) ? 16'h0000 : (p == 1) ? 16'h8765 : (p == 2) ? 16'h0010 : 16'hC00B,
              1'b1, p[0], p[1], 4'(b), "R8 forced blank");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule